// File: doc/BRIEF.md
# Packed Sign-Magnitude Shared Multiplier

This block forms several small signed products with one wide unsigned multiply. Each operand is a 6-bit sign-magnitude value. Bit 5 is the sign (1 means negative) and bits 4:0 are the magnitude, so -4 is written 1_00100 and +4 is written 0_00100. The block packs only the magnitudes into the two multiplier operands, with zero gaps between them, so that the partial products land in separate bit fields of the result. Each product sign is the exclusive-OR of its two operand signs and is applied only after the multiply. No sign extension or correction term is needed.

Two packings share the same multiplier. In triple mode, one input magnitude is multiplied by three weights placed side by side with a 5-bit gap between them. The three 10-bit result fields are the three products. In pair mode, two inputs and two weights are packed so that the two wanted products occupy the top and bottom result fields. The two cross terms fall in the middle bits and are thrown away. Every magnitude is joined to its sign and converted to an 11-bit two's-complement value, so the results can go straight into an adder tree. A valid flag travels through the same pipeline, which has one or two register stages.

Top module: `psm_shared_mult`

## Requirements
- R1: Each output equals the signed product of its operands. Its sign is the XOR of the two operand sign bits, and it is presented as an 11-bit two's-complement number.
- R2: With `mode`=0 (triple), `prod_1`, `prod_2` and `prod_3` are `in_a` times `w_1`, `w_2` and `w_3` respectively.
- R3: With `mode`=1 (pair), `prod_1` is `in_a`×`w_1`, `prod_2` is `in_b`×`w_2` and `prod_3` is 0. The cross terms `in_a`×`w_2` and `in_b`×`w_1` never change either output.
- R4: `in_b` has no effect on any output in triple mode, and `w_3` has no effect on any output in pair mode.
- R5: A product with zero magnitude is output as 0, whatever its sign bits are, including for an operand of 1_00000.
- R6: `out_valid` follows `in_valid` exactly PIPE_STAGES clock edges later (default 2). The outputs shown with it belong to the operands that were presented with that `in_valid`. Back-to-back operations in mixed modes are accepted on every cycle.
- R7: While `rst_n` is low, `out_valid` and all three products are 0.
- R8: The extreme magnitudes ±31×±31 produce ±961 in every lane without corrupting the other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on the inputs are to be processed |
| mode | input | 1 | 0 = three products on a shared input, 1 = two independent products |
| in_a | input | 6 | First input operand, sign-magnitude |
| in_b | input | 6 | Second input operand (pair mode only), sign-magnitude |
| w_1 | input | 6 | Weight for product 1, sign-magnitude |
| w_2 | input | 6 | Weight for product 2, sign-magnitude |
| w_3 | input | 6 | Weight for product 3 (triple mode only), sign-magnitude |
| out_valid | output | 1 | Products on the outputs are valid |
| prod_1 | output | 11 | Product 1, two's complement |
| prod_2 | output | 11 | Product 2, two's complement |
| prod_3 | output | 11 | Product 3, two's complement; 0 in pair mode |

## Verification
The bench pushes all-ones magnitudes through both packings, because that is where a gap that is too narrow would let one field carry into its neighbour or let a cross term bleed into a kept field. A packing error of that kind shows up as wrong values in adjacent lanes. Negative-zero operands and mixed-sign products check the XOR sign path. A converter that is wrong there would emit a negated or non-zero result. Operations of both modes are issued back to back to expose a mode bit that is out of step with its data, which would decode one operation with the other packing. Idle and ignored operands are varied to show that they leave the outputs untouched.

// File: rtl/psm_pkg.sv
package psm_pkg;
    // Packing selector shared by the packer and the lane decoder
    typedef enum logic {
        MODE_TRIPLE = 1'b0,
        MODE_PAIR   = 1'b1
    } psm_mode_e;
endpackage

// File: rtl/psm_pack.sv
module psm_pack
    import psm_pkg::*;
#(
    parameter int MAG_W = 5
) (
    input  psm_mode_e            mode,
    input  logic [MAG_W-1:0]     a_mag,
    input  logic [MAG_W-1:0]     b_mag,
    input  logic [MAG_W-1:0]     w1_mag,
    input  logic [MAG_W-1:0]     w2_mag,
    input  logic [MAG_W-1:0]     w3_mag,
    output logic [5*MAG_W-1:0]   x_op,
    output logic [3*MAG_W-1:0]   y_op
);
    localparam int X_W = 5 * MAG_W;
    localparam int Y_W = 3 * MAG_W;

    always_comb begin
        if (mode == MODE_TRIPLE) begin
            // weights spaced one magnitude width apart, shared input alone
            x_op = {w1_mag, {MAG_W{1'b0}}, w2_mag, {MAG_W{1'b0}}, w3_mag};
            y_op = {{(Y_W-MAG_W){1'b0}}, a_mag};
        end else begin
            // inputs spaced three widths apart, weights one width apart
            x_op = {a_mag, {(X_W-2*MAG_W){1'b0}}, b_mag};
            y_op = {w1_mag, {MAG_W{1'b0}}, w2_mag};
        end
    end
endmodule

// File: rtl/psm_lane.sv
module psm_lane #(
    parameter int MAG_W = 5
) (
    input  logic [2*MAG_W-1:0] mag,
    input  logic               neg,
    output logic [2*MAG_W:0]   tc
);
    localparam int TC_W = 2 * MAG_W + 1;

    logic [TC_W-1:0] ext;

    always_comb begin
        ext = {1'b0, mag};
        tc  = neg ? (~ext + TC_W'(1)) : ext;
    end

    always_comb begin
        // R5
        if (mag == '0) zero_pos_chk: assert (tc == '0);
        // R1
        if (!$isunknown(tc))
            conv_mag_chk: assert ((tc[TC_W-1] ? (~tc + TC_W'(1)) : tc) == ext);
    end
endmodule

// File: rtl/psm_shared_mult.sv
module psm_shared_mult
    import psm_pkg::*;
#(
    parameter int MAG_W       = 5,
    parameter int PIPE_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               mode,
    input  logic [MAG_W:0]     in_a,
    input  logic [MAG_W:0]     in_b,
    input  logic [MAG_W:0]     w_1,
    input  logic [MAG_W:0]     w_2,
    input  logic [MAG_W:0]     w_3,
    output logic               out_valid,
    output logic [2*MAG_W:0]   prod_1,
    output logic [2*MAG_W:0]   prod_2,
    output logic [2*MAG_W:0]   prod_3
);
    localparam int PM_W  = 2 * MAG_W;
    localparam int TC_W  = PM_W + 1;
    localparam int X_W   = 5 * MAG_W;
    localparam int Y_W   = 3 * MAG_W;
    localparam int R_W   = X_W + Y_W;
    localparam int NLANE = 3;
    localparam logic signed [TC_W-1:0] LIM = TC_W'((2**MAG_W - 1) * (2**MAG_W - 1));

    typedef struct packed {
        logic                 vld;
        logic                 pair;
        logic [X_W-1:0]       x;
        logic [Y_W-1:0]       y;
        logic [NLANE-1:0]     sgn;
    } op_t;

    typedef struct packed {
        logic                        vld;
        logic                        pair;
        logic [NLANE-1:0][TC_W-1:0]  p;
    } res_t;

    logic [X_W-1:0]  x_w;
    logic [Y_W-1:0]  y_w;
    op_t             op_d, op_s;
    res_t            res_d, res_q;
    logic [R_W-1:0]  raw;
    logic [PM_W-1:0] lane_mag [NLANE];
    logic [TC_W-1:0] lane_tc  [NLANE];

    psm_pack #(.MAG_W(MAG_W)) u_pack (
        .mode   (psm_mode_e'(mode)),
        .a_mag  (in_a[MAG_W-1:0]),
        .b_mag  (in_b[MAG_W-1:0]),
        .w1_mag (w_1[MAG_W-1:0]),
        .w2_mag (w_2[MAG_W-1:0]),
        .w3_mag (w_3[MAG_W-1:0]),
        .x_op   (x_w),
        .y_op   (y_w)
    );

    // operand stage: packed magnitudes plus product signs
    always_comb begin
        op_d      = '0;
        op_d.vld  = in_valid;
        op_d.pair = mode;
        op_d.x    = x_w;
        op_d.y    = y_w;
        if (mode == MODE_TRIPLE)
            op_d.sgn = {in_a[MAG_W] ^ w_3[MAG_W], in_a[MAG_W] ^ w_2[MAG_W], in_a[MAG_W] ^ w_1[MAG_W]};
        else
            op_d.sgn = {1'b0, in_b[MAG_W] ^ w_2[MAG_W], in_a[MAG_W] ^ w_1[MAG_W]};
    end

    generate
        if (PIPE_STAGES >= 2) begin : g_in_reg
            op_t op_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) op_q <= '0;
                else        op_q <= op_d;
            end
            assign op_s = op_q;

            // R6
            lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> ##1 out_valid);
            // R6
            idle_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> ##1 !out_valid);
        end else begin : g_in_comb
            assign op_s = op_d;

            // R6
            lat_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            // R6
            idle_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
        end
    endgenerate

    // the one shared wide unsigned multiply
    assign raw = {{Y_W{1'b0}}, op_s.x} * {{X_W{1'b0}}, op_s.y};

    always_comb begin
        if (op_s.pair) begin
            lane_mag[0] = raw[8*MAG_W-1:6*MAG_W];
            lane_mag[1] = raw[2*MAG_W-1:0];
            lane_mag[2] = '0;
        end else begin
            lane_mag[0] = raw[6*MAG_W-1:4*MAG_W];
            lane_mag[1] = raw[4*MAG_W-1:2*MAG_W];
            lane_mag[2] = raw[2*MAG_W-1:0];
        end
    end

    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_lane
            psm_lane #(.MAG_W(MAG_W)) u_lane (
                .mag (lane_mag[g]),
                .neg (op_s.sgn[g]),
                .tc  (lane_tc[g])
            );
            always_comb res_d.p[g] = lane_tc[g];
        end
    endgenerate

    always_comb begin
        res_d.vld  = op_s.vld;
        res_d.pair = op_s.pair;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.vld;
    assign prod_1    = res_q.p[0];
    assign prod_2    = res_q.p[1];
    assign prod_3    = res_q.p[2];

    // R7
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && prod_1 == '0 && prod_2 == '0 && prod_3 == '0));
    // R3
    pair_third_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && res_q.pair) |-> prod_3 == '0);
    // R8
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(prod_1) <= LIM && $signed(prod_1) >= -LIM &&
                       $signed(prod_2) <= LIM && $signed(prod_2) >= -LIM &&
                       $signed(prod_3) <= LIM && $signed(prod_3) >= -LIM));
endmodule

// File: tb/tb_psm_shared_mult.sv
module tb_psm_shared_mult;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode = 1'b0;
    logic [5:0]  in_a = '0, in_b = '0, w_1 = '0, w_2 = '0, w_3 = '0;
    logic        out_valid;
    logic [10:0] prod_1, prod_2, prod_3;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    psm_shared_mult #(.MAG_W(5), .PIPE_STAGES(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .in_a(in_a), .in_b(in_b), .w_1(w_1), .w_2(w_2), .w_3(w_3),
        .out_valid(out_valid), .prod_1(prod_1), .prod_2(prod_2), .prod_3(prod_3)
    );

    function automatic logic [5:0] sm(int v);
        return {v < 0, 5'((v < 0) ? -v : v)};
    endfunction

    function automatic int dec(logic [5:0] v);
        return v[5] ? -int'(v[4:0]) : int'(v[4:0]);
    endfunction

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic drive(logic m, logic [5:0] a, logic [5:0] b,
                         logic [5:0] x1, logic [5:0] x2, logic [5:0] x3);
        in_valid = 1'b1; mode = m;
        in_a = a; in_b = b; w_1 = x1; w_2 = x2; w_3 = x3;
    endtask

    task automatic idle();
        in_valid = 1'b0; in_a = 6'h2A; in_b = 6'h15; w_1 = 6'h3F; w_2 = 6'h1F; w_3 = 6'h33;
    endtask

    // compare outputs against the operation (m,a,b,x1..x3)
    task automatic expect_op(string req, logic m, logic [5:0] a, logic [5:0] b,
                             logic [5:0] x1, logic [5:0] x2, logic [5:0] x3);
        int e1, e2, e3;
        e1 = dec(a) * dec(x1);
        e2 = m ? dec(b) * dec(x2) : dec(a) * dec(x2);
        e3 = m ? 0 : dec(a) * dec(x3);
        chk({req, " valid"}, int'(out_valid), 1);
        chk({req, " p1"}, int'($signed(prod_1)), e1);
        chk({req, " p2"}, int'($signed(prod_2)), e2);
        chk({req, " p3"}, int'($signed(prod_3)), e3);
    endtask

    // issue one operation alone and check it after the pipeline
    task automatic one_op(string req, logic m, logic [5:0] a, logic [5:0] b,
                          logic [5:0] x1, logic [5:0] x2, logic [5:0] x3);
        @(negedge clk);
        drive(m, a, b, x1, x2, x3);
        @(negedge clk);
        idle();
        repeat (LAT - 1) @(negedge clk);
        expect_op(req, m, a, b, x1, x2, x3);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        drive(1'b0, sm(5), sm(3), sm(7), sm(9), sm(11));
        repeat (3) @(negedge clk);
        chk("R7 valid in reset", int'(out_valid), 0);
        chk("R7 p1 in reset", int'(prod_1), 0);
        chk("R7 p2 in reset", int'(prod_2), 0);
        chk("R7 p3 in reset", int'(prod_3), 0);
        idle();
        rst_n = 1'b1;
        repeat (LAT + 1) @(negedge clk);
        chk("R7 valid after release", int'(out_valid), 0);
    endtask

    task automatic t_triple();
        one_op("R2 mixed", 1'b0, sm(3), sm(0), sm(5), sm(-7), sm(11));
        one_op("R2 R1 neg in", 1'b0, sm(-31), sm(0), sm(31), sm(-31), sm(1));
        one_op("R1 all neg", 1'b0, sm(-1), sm(0), sm(-1), sm(-1), sm(-1));
        one_op("R8 triple max", 1'b0, sm(31), sm(0), sm(31), sm(31), sm(31));
    endtask

    task automatic t_pair();
        one_op("R3 R8 pair max", 1'b1, sm(31), sm(-31), sm(-31), sm(31), sm(0));
        one_op("R3 pair mixed", 1'b1, sm(7), sm(9), sm(-13), sm(2), sm(0));
        one_op("R8 pair neg", 1'b1, sm(-31), sm(-31), sm(31), sm(31), sm(0));
    endtask

    task automatic t_ignored();
        // R4: in_b altered in triple mode, w3 altered in pair mode
        one_op("R4 triple b=0", 1'b0, sm(9), sm(0), sm(4), sm(-6), sm(8));
        one_op("R4 triple b=-31", 1'b0, sm(9), sm(-31), sm(4), sm(-6), sm(8));
        one_op("R4 pair w3=-31", 1'b1, sm(12), sm(-5), sm(3), sm(10), sm(-31));
        one_op("R4 pair w3=+17", 1'b1, sm(12), sm(-5), sm(3), sm(10), sm(17));
    endtask

    task automatic t_zero();
        // R5: negative zero operands and zero magnitudes with set signs
        one_op("R5 neg zero in", 1'b0, 6'b100000, sm(0), sm(-5), sm(7), sm(-31));
        one_op("R5 neg zero w", 1'b1, sm(-9), sm(4), 6'b100000, sm(-3), sm(0));
        one_op("R5 pair b zero", 1'b1, sm(31), 6'b100000, sm(31), sm(-31), sm(0));
    endtask

    task automatic t_latency();
        @(negedge clk);
        drive(1'b0, sm(2), sm(0), sm(3), sm(4), sm(5));
        @(negedge clk);
        idle();
        chk("R6 not early", int'(out_valid), 0);
        repeat (LAT - 1) @(negedge clk);
        chk("R6 on time", int'(out_valid), 1);
        @(negedge clk);
        chk("R6 single pulse", int'(out_valid), 0);
    endtask

    task automatic t_stream();
        localparam int N = 8;
        logic       sm_m [N];
        logic [5:0] sa [N], sb [N], s1 [N], s2 [N], s3 [N];
        for (int i = 0; i < N; i++) begin
            sm_m[i] = i[0];
            sa[i] = sm(((i * 7) % 63) - 31);
            sb[i] = sm(((i * 13 + 5) % 63) - 31);
            s1[i] = sm(((i * 11 + 3) % 63) - 31);
            s2[i] = sm(31 - ((i * 17) % 63));
            s3[i] = sm(((i * 5 + 20) % 63) - 31);
        end
        for (int i = 0; i < N + LAT; i++) begin
            @(negedge clk);
            if (i >= LAT)
                expect_op("R6 stream", sm_m[i-LAT], sa[i-LAT], sb[i-LAT],
                          s1[i-LAT], s2[i-LAT], s3[i-LAT]);
            if (i < N) drive(sm_m[i], sa[i], sb[i], s1[i], s2[i], s3[i]);
            else       idle();
        end
    endtask

    task automatic t_sweep();
        for (int a = -31; a <= 31; a += 10) begin
            for (int w = -31; w <= 31; w += 15) begin
                one_op("R1 R2 sweep", 1'b0, sm(a), sm(0), sm(w), sm(-w), sm(31 - (w < 0 ? -w : w)));
                one_op("R1 R3 sweep", 1'b1, sm(a), sm(w), sm(-a), sm(w), sm(0));
            end
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(200_000 * 10);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle();
        t_reset();
        t_latency();
        t_triple();
        t_pair();
        t_ignored();
        t_zero();
        t_stream();
        t_sweep();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule